// File: doc/BRIEF.md
# Two-Channel Bus Break Detector

This block watches a processor's bus activity one cycle at a time and raises a break interrupt request when programmed conditions hold. Two channels, A and B, each compare an address under a bit mask and filter the cycle by its bus master, cycle kind, direction and operand size. Channel B also offers a masked data comparison, a choice of which address and data bus it watches, and a repeat counter that lets a condition pass a set number of times before the break fires.

The channels can raise requests on their own, or they can form a chain in which a channel A hit arms the unit and only a later channel B hit produces the break. For instruction fetches, each channel can report at once or wait until the fetched instruction retires. Software sets up the block through a small register write port and clears the sticky per-channel hit flags by writing ones. The single `breakReq` output goes to an interrupt controller.

Top module: `bus_break_unit`

## Requirements
- R1: Channel A matches only when `(busAddrMain ^ cmp) & ~mask` is zero, where cmp is register 0 and mask is register 1. A mask bit of 1 makes that address bit don't-care.
- R2: Each channel's control register (A at register 2, B at register 7) carries allow bitmaps, and a bus cycle matches only if every one of its attributes is allowed. Bit 0 allows CPU (`busMaster`=0) and bit 1 allows DMA (`busMaster`=1). Bit 2 allows fetch (`busFetch`=1) and bit 3 allows data access. Bit 4 allows read (`busWrite`=0) and bit 5 allows write. Bits 6, 7 and 8 allow byte, word and longword (`busSize` 0, 1 and 2). `busSize`=3 never matches, and an all-zero field never matches.
- R3: Channel B compares register 3 under mask register 4. Control bits 12:11 pick the address bus it compares: 1 selects X, 2 selects Y, and 0 or 3 selects main.
- R4: When bit 15 of channel B's control is set, channel B also needs `(data ^ reg5) & ~reg6` to be zero. Bits 14:13 pick the data bus: 1 selects X, 2 selects Y, and 0 or 3 selects main.
- R5: A data-access match, or a fetch match with control bit 9 clear, sets the channel status flag at the clock edge that samples the bus cycle.
- R6: A fetch match with control bit 9 set is held pending. The status flag is then set at the edge that samples `retire`=1 in a later cycle.
- R7: With register 8 bit 0 set (sequential mode), a channel A hit arms the unit and does not set status A. A channel B hit while the unit is unarmed is ignored. A channel B hit while armed sets status B and disarms the unit.
- R8: With register 8 bit 1 set, the status B flag is set only on every Nth qualifying channel B hit, where N is register 9 (12 bits), and the counter then reloads. A write to register 9 reloads the counter. N of 0 or 1 fires on every hit.
- R9: Status flags are sticky. Writing register 10 with bit 0 (A) or bit 1 (B) set clears the matching flag. A new hit in the same cycle wins over the clear.
- R10: `breakReq` is the OR of each status flag ANDed with its channel's control bit 10 (interrupt enable). A flag whose enable is clear still sets but does not raise `breakReq`.
- R11: After reset, every register is zero, both flags and `breakReq` are low, and no bus cycle matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register index |
| regWrData | input | 32 | Register write data |
| busValid | input | 1 | Bus record below is a real cycle |
| busAddrMain | input | 32 | Main instruction/data address bus |
| busAddrX | input | 32 | X-memory address bus |
| busAddrY | input | 32 | Y-memory address bus |
| busDataMain | input | 32 | Main data bus |
| busDataX | input | 32 | X-memory data bus |
| busDataY | input | 32 | Y-memory data bus |
| busMaster | input | 1 | 0 CPU, 1 DMA |
| busFetch | input | 1 | 1 instruction fetch, 0 data access |
| busWrite | input | 1 | 1 write, 0 read |
| busSize | input | 2 | 0 byte, 1 word, 2 longword |
| retire | input | 1 | Pending fetched instruction has retired |
| statusA | output | 1 | Sticky channel A hit flag |
| statusB | output | 1 | Sticky channel B hit flag |
| breakReq | output | 1 | Break interrupt request |

## Verification
An immediate hit shows up on the status flags and on `breakReq` one edge after the bus cycle is sampled. A deferred fetch hit shows up one edge after `retire` is sampled. A register write takes effect at the edge that samples it. The bench drives every input on a falling edge, holds it for one full cycle and reads the outputs on the next falling edge, so each check looks exactly one edge after its cause. Sweeps over every qualifier bitmap and every bus attribute, over a masked address byte and over every bus-select pairing compare each result with a value computed from the requirement formulas.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int QUAL_W  = 9;
  localparam int QCFG_W  = 11;
  localparam int BCFG_W  = 16;
  localparam int AFTER_BIT = 9;
  localparam int IE_BIT    = 10;

  localparam logic [3:0] OFF_A_CMP   = 4'd0;
  localparam logic [3:0] OFF_A_MASK  = 4'd1;
  localparam logic [3:0] OFF_A_CTL   = 4'd2;
  localparam logic [3:0] OFF_B_CMP   = 4'd3;
  localparam logic [3:0] OFF_B_MASK  = 4'd4;
  localparam logic [3:0] OFF_B_DATA  = 4'd5;
  localparam logic [3:0] OFF_B_DMASK = 4'd6;
  localparam logic [3:0] OFF_B_CTL   = 4'd7;
  localparam logic [3:0] OFF_MODE    = 4'd8;
  localparam logic [3:0] OFF_COUNT   = 4'd9;
  localparam logic [3:0] OFF_CLR     = 4'd10;

  // control -> datapath strobes
  typedef struct packed {
    logic cntReload;
    logic cntStep;
  } ctrlStrobe_t;

  // datapath -> control summary
  typedef struct packed {
    logic hitA;
    logic hitB;
    logic fetchCyc;
    logic cntLast;
    logic seqMode;
    logic repEn;
    logic afterA;
    logic afterB;
    logic ieA;
    logic ieB;
    logic clrA;
    logic clrB;
  } dpInfo_t;
endpackage

// File: rtl/brk_qual.sv
module brk_qual
  import brk_pkg::*;
(
  input  logic [QUAL_W-1:0] allow,
  input  logic              busMaster,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  output logic              qualOk
);
  logic masterOk, cycOk, dirOk, sizeOk;

  always_comb begin
    masterOk = busMaster ? allow[1] : allow[0];
    cycOk    = busFetch  ? allow[2] : allow[3];
    dirOk    = busWrite  ? allow[5] : allow[4];
    case (busSize)
      2'd0:    sizeOk = allow[6];
      2'd1:    sizeOk = allow[7];
      2'd2:    sizeOk = allow[8];
      default: sizeOk = 1'b0;
    endcase
    qualOk = masterOk & cycOk & dirOk & sizeOk;
  end
endmodule

// File: rtl/brk_match_path.sv
module brk_match_path
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddrMain,
  input  logic [ADDR_W-1:0] busAddrX,
  input  logic [ADDR_W-1:0] busAddrY,
  input  logic [DATA_W-1:0] busDataMain,
  input  logic [DATA_W-1:0] busDataX,
  input  logic [DATA_W-1:0] busDataY,
  input  logic              busMaster,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  ctrlStrobe_t       strobe,
  output dpInfo_t           info
);
  localparam int NCH = 2;

  logic [ADDR_W-1:0] cmpAddrA, maskAddrA, cmpAddrB, maskAddrB;
  logic [DATA_W-1:0] cmpDataB, maskDataB;
  logic [QCFG_W-1:0] cfgA;
  logic [BCFG_W-1:0] cfgB;
  logic              seqMode, repEn;
  logic [CNT_W-1:0]  cntLoad, cnt;

  logic [QUAL_W-1:0] allowArr [NCH];
  logic [NCH-1:0]    qualOk;

  logic [ADDR_W-1:0] selAddrB;
  logic [DATA_W-1:0] selDataB;
  logic              addrOkA, addrOkB, dataOkB;

  wire wrHit = regWrEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpAddrA  <= '0;
      maskAddrA <= '0;
      cmpAddrB  <= '0;
      maskAddrB <= '0;
      cmpDataB  <= '0;
      maskDataB <= '0;
      cfgA      <= '0;
      cfgB      <= '0;
      seqMode   <= 1'b0;
      repEn     <= 1'b0;
      cntLoad   <= '0;
    end else if (wrHit) begin
      case (regAddr)
        OFF_A_CMP:   cmpAddrA  <= regWrData[ADDR_W-1:0];
        OFF_A_MASK:  maskAddrA <= regWrData[ADDR_W-1:0];
        OFF_A_CTL:   cfgA      <= regWrData[QCFG_W-1:0];
        OFF_B_CMP:   cmpAddrB  <= regWrData[ADDR_W-1:0];
        OFF_B_MASK:  maskAddrB <= regWrData[ADDR_W-1:0];
        OFF_B_DATA:  cmpDataB  <= regWrData[DATA_W-1:0];
        OFF_B_DMASK: maskDataB <= regWrData[DATA_W-1:0];
        OFF_B_CTL:   cfgB      <= regWrData[BCFG_W-1:0];
        OFF_MODE: begin
          seqMode <= regWrData[0];
          repEn   <= regWrData[1];
        end
        OFF_COUNT:   cntLoad   <= regWrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // repeat counter: a count write wins over the control strobes
  always_ff @(posedge clk) begin
    if (!rstN)
      cnt <= '0;
    else if (regWrEn && regAddr == OFF_COUNT)
      cnt <= regWrData[CNT_W-1:0];
    else if (strobe.cntReload)
      cnt <= cntLoad;
    else if (strobe.cntStep)
      cnt <= cnt - CNT_W'(1);
  end

  assign allowArr[0] = cfgA[QUAL_W-1:0];
  assign allowArr[1] = cfgB[QUAL_W-1:0];

  for (genvar ch = 0; ch < NCH; ch++) begin : gQual
    brk_qual u_qual (
      .allow     (allowArr[ch]),
      .busMaster (busMaster),
      .busFetch  (busFetch),
      .busWrite  (busWrite),
      .busSize   (busSize),
      .qualOk    (qualOk[ch])
    );
  end

  always_comb begin
    case (cfgB[12:11])
      2'd1:    selAddrB = busAddrX;
      2'd2:    selAddrB = busAddrY;
      default: selAddrB = busAddrMain;
    endcase
    case (cfgB[14:13])
      2'd1:    selDataB = busDataX;
      2'd2:    selDataB = busDataY;
      default: selDataB = busDataMain;
    endcase
    addrOkA = ((busAddrMain ^ cmpAddrA) & ~maskAddrA) == '0;
    addrOkB = ((selAddrB ^ cmpAddrB) & ~maskAddrB) == '0;
    dataOkB = !cfgB[15] || (((selDataB ^ cmpDataB) & ~maskDataB) == '0);
  end

  always_comb begin
    info.hitA     = busValid & addrOkA & qualOk[0];
    info.hitB     = busValid & addrOkB & dataOkB & qualOk[1];
    info.fetchCyc = busFetch;
    info.cntLast  = cnt <= CNT_W'(1);
    info.seqMode  = seqMode;
    info.repEn    = repEn;
    info.afterA   = cfgA[AFTER_BIT];
    info.afterB   = cfgB[AFTER_BIT];
    info.ieA      = cfgA[IE_BIT];
    info.ieB      = cfgB[IE_BIT];
    info.clrA     = regWrEn && regAddr == OFF_CLR && regWrData[0];
    info.clrB     = regWrEn && regAddr == OFF_CLR && regWrData[1];
  end
endmodule

// File: rtl/brk_sequencer.sv
module brk_sequencer
  import brk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpInfo_t     info,
  input  logic        retire,
  output ctrlStrobe_t strobe,
  output logic        statusA,
  output logic        statusB,
  output logic        armed,
  output logic        qualB,
  output logic        breakReq
);
  logic pendA, pendB;
  logic deferA, deferB, evtA, evtB, fireB;

  always_comb begin
    deferA = info.hitA & info.afterA & info.fetchCyc;
    deferB = info.hitB & info.afterB & info.fetchCyc;
    evtA   = (info.hitA & ~deferA) | (pendA & retire);
    evtB   = (info.hitB & ~deferB) | (pendB & retire);
    qualB  = evtB & (~info.seqMode | armed);
    fireB  = qualB & (~info.repEn | info.cntLast);
    strobe.cntStep   = qualB & info.repEn & ~info.cntLast;
    strobe.cntReload = qualB & info.repEn & info.cntLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendA   <= 1'b0;
      pendB   <= 1'b0;
      armed   <= 1'b0;
      statusA <= 1'b0;
      statusB <= 1'b0;
    end else begin
      pendA   <= (pendA & ~retire) | deferA;
      pendB   <= (pendB & ~retire) | deferB;
      armed   <= info.seqMode & (evtA | (armed & ~fireB));
      statusA <= (evtA & ~info.seqMode) | (statusA & ~info.clrA);
      statusB <= fireB | (statusB & ~info.clrB);
    end
  end

  assign breakReq = (statusA & info.ieA) | (statusB & info.ieB);
endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddrMain,
  input  logic [ADDR_W-1:0] busAddrX,
  input  logic [ADDR_W-1:0] busAddrY,
  input  logic [DATA_W-1:0] busDataMain,
  input  logic [DATA_W-1:0] busDataX,
  input  logic [DATA_W-1:0] busDataY,
  input  logic              busMaster,
  input  logic              busFetch,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic              retire,
  output logic              statusA,
  output logic              statusB,
  output logic              breakReq
);
  ctrlStrobe_t strobe;
  dpInfo_t     info;
  logic        armed, qualB;
  logic        seqOn, repOn, cntLast;

  assign seqOn   = info.seqMode;
  assign repOn   = info.repEn;
  assign cntLast = info.cntLast;

  brk_match_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) u_path (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .busValid,
    .busAddrMain, .busAddrX, .busAddrY,
    .busDataMain, .busDataX, .busDataY,
    .busMaster, .busFetch, .busWrite, .busSize,
    .strobe, .info
  );

  brk_sequencer u_seq (
    .clk, .rstN, .info, .retire, .strobe,
    .statusA, .statusB, .armed, .qualB, .breakReq
  );
endmodule

// File: rtl/bus_break_chk.sv
module bus_break_chk
  import brk_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [3:0]       regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic             statusA,
  input logic             statusB,
  input logic             breakReq,
  input logic             armed,
  input logic             qualB,
  input logic             seqOn,
  input logic             repOn,
  input logic             cntLast
);
  // R9
  sticky_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusA && !(regWrEn && regAddr == OFF_CLR && regWrData[0]) |=> statusA);

  // R9
  sticky_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusB && !(regWrEn && regAddr == OFF_CLR && regWrData[1]) |=> statusB);

  // R7
  seq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqOn && !armed |=> !$rose(statusB));

  // R7
  armed_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> $past(seqOn));

  // R8
  rep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    repOn && qualB && !cntLast && !statusB |=> !statusB);

  // R10
  req_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> (statusA || statusB));
endmodule

bind bus_break_unit bus_break_chk #(.REG_W(REG_W)) u_chk (
  .clk, .rstN, .regWrEn, .regAddr, .regWrData,
  .statusA, .statusB, .breakReq,
  .armed, .qualB, .seqOn, .repOn, .cntLast
);

// File: tb/tb_bus_break_unit.sv
module tb_bus_break_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ALLQ = 32'h1FF;
  localparam logic [31:0] IE   = 32'h400;
  localparam logic [31:0] AFT  = 32'h200;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddrMain = '0, busAddrX = '0, busAddrY = '0;
  logic [31:0] busDataMain = '0, busDataX = '0, busDataY = '0;
  logic        busMaster = 1'b0, busFetch = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = 2'd2;
  logic        retire = 1'b0;
  logic        statusA, statusB, breakReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_break_unit dut (
    .clk, .rstN, .regWrEn, .regAddr, .regWrData, .busValid,
    .busAddrMain, .busAddrX, .busAddrY,
    .busDataMain, .busDataX, .busDataY,
    .busMaster, .busFetch, .busWrite, .busSize, .retire,
    .statusA, .statusB, .breakReq
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    busValid = 1'b1;
    @(negedge clk);
    busValid = 1'b0;
  endtask

  task automatic retirePulse();
    @(negedge clk);
    retire = 1'b1;
    @(negedge clk);
    retire = 1'b0;
  endtask

  task automatic plainBus(input logic [31:0] a);
    busMaster = 1'b0; busFetch = 1'b0; busWrite = 1'b0; busSize = 2'd2;
    busAddrMain = a; busAddrX = 32'h999; busAddrY = 32'h999;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 statusA", statusA, 1'b0);
    chk("R11 statusB", statusB, 1'b0);
    chk("R11 breakReq", breakReq, 1'b0);
    plainBus(32'h0);
    pulse();
    chk("R11 no match A", statusA, 1'b0);
    chk("R11 no match B", statusB, 1'b0);

    // R2 qualifier sweep on channel A
    wr(4'd0, 32'h100);
    wr(4'd1, 32'h0);
    for (int cfg = 0; cfg < 512; cfg++) begin
      wr(4'd2, IE | 32'(cfg));
      for (int m = 0; m < 2; m++)
        for (int f = 0; f < 2; f++)
          for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++) begin
              logic e;
              e = cfg[m] & (f != 0 ? cfg[2] : cfg[3]) & (w != 0 ? cfg[5] : cfg[4])
                  & ((s < 3) ? cfg[6+s] : 1'b0);
              busAddrMain = 32'h100;
              busMaster = m[0]; busFetch = f[0]; busWrite = w[0]; busSize = s[1:0];
              pulse();
              chk("R2 qualifier", statusA, e);
              if (statusA) wr(4'd10, 32'h1);
            end
    end

    // R1 address mask sweep on channel A
    wr(4'd2, IE | ALLQ);
    wr(4'd0, 32'h1234_00A5);
    wr(4'd1, 32'h0000_000F);
    for (int a = 0; a < 256; a++) begin
      plainBus(32'h1234_0000 | 32'(a));
      pulse();
      chk("R1 mask", statusA, (((a[7:0] ^ 8'hA5) & 8'hF0) == 8'h00));
      if (statusA) wr(4'd10, 32'h1);
    end
    plainBus(32'h1235_00A5);
    pulse();
    chk("R1 upper bit", statusA, 1'b0);

    // R3 channel B address bus selection
    wr(4'd2, 32'h0);
    wr(4'd3, 32'h200);
    wr(4'd4, 32'h0);
    for (int sel = 0; sel < 4; sel++) begin
      wr(4'd7, IE | ALLQ | (32'(sel) << 11));
      for (int b = 0; b < 3; b++) begin
        plainBus(32'h999);
        if (b == 0) busAddrMain = 32'h200;
        if (b == 1) busAddrX = 32'h200;
        if (b == 2) busAddrY = 32'h200;
        pulse();
        chk("R3 addr select", statusB, (sel == 3 ? 0 : sel) == b);
        if (statusB) wr(4'd10, 32'h2);
      end
    end

    // R4 channel B data compare
    wr(4'd5, 32'hCAFE);
    wr(4'd6, 32'h000F);
    for (int sel = 0; sel < 3; sel++) begin
      wr(4'd7, IE | ALLQ | 32'h8000 | (32'(sel) << 13));
      for (int b = 0; b < 3; b++)
        for (int v = 0; v < 2; v++) begin
          plainBus(32'h200);
          busDataMain = 32'h1111; busDataX = 32'h1111; busDataY = 32'h1111;
          if (b == 0) busDataMain = (v == 0) ? 32'hCAF0 : 32'hCBFE;
          if (b == 1) busDataX    = (v == 0) ? 32'hCAF0 : 32'hCBFE;
          if (b == 2) busDataY    = (v == 0) ? 32'hCAF0 : 32'hCBFE;
          pulse();
          chk("R4 data compare", statusB, (sel == b) && (v == 0));
          if (statusB) wr(4'd10, 32'h2);
        end
    end

    // R5 immediate report and R10 request
    wr(4'd7, 32'h0);
    wr(4'd2, IE | ALLQ | AFT);
    plainBus(32'h1234_00A5);
    chk("R5 idle req", breakReq, 1'b0);
    pulse();
    chk("R5 data access immediate", statusA, 1'b1);
    chk("R10 request", breakReq, 1'b1);
    wr(4'd10, 32'h1);
    chk("R9 clear A", statusA, 1'b0);
    chk("R10 request drops", breakReq, 1'b0);

    // R6 deferred fetch
    busFetch = 1'b1;
    pulse();
    chk("R6 pending no status", statusA, 1'b0);
    busFetch = 1'b0; busAddrMain = 32'h0;
    @(negedge clk);
    chk("R6 still pending", statusA, 1'b0);
    retirePulse();
    chk("R6 after retire", statusA, 1'b1);
    wr(4'd10, 32'h1);
    retirePulse();
    chk("R6 single shot", statusA, 1'b0);
    wr(4'd2, IE | ALLQ);
    busFetch = 1'b1; busAddrMain = 32'h1234_00A5;
    pulse();
    chk("R5 fetch immediate", statusA, 1'b1);
    wr(4'd10, 32'h1);

    // R10 enable clear
    wr(4'd2, ALLQ);
    plainBus(32'h1234_00A5);
    pulse();
    chk("R10 flag without enable", statusA, 1'b1);
    chk("R10 no request", breakReq, 1'b0);
    wr(4'd10, 32'h1);

    // R7 sequential mode
    wr(4'd2, IE | ALLQ);
    wr(4'd7, IE | ALLQ);
    wr(4'd8, 32'h1);
    plainBus(32'h200);
    pulse();
    chk("R7 B unarmed ignored", statusB, 1'b0);
    plainBus(32'h1234_00A5);
    pulse();
    chk("R7 A arms no status", statusA, 1'b0);
    chk("R7 A arms no request", breakReq, 1'b0);
    plainBus(32'h200);
    pulse();
    chk("R7 B armed fires", statusB, 1'b1);
    chk("R7 request", breakReq, 1'b1);
    wr(4'd10, 32'h2);
    pulse();
    chk("R7 disarmed", statusB, 1'b0);

    // R8 repeat counter
    wr(4'd8, 32'h2);
    wr(4'd9, 32'd3);
    for (int round = 0; round < 2; round++)
      for (int k = 1; k <= 3; k++) begin
        pulse();
        chk("R8 repeat", statusB, k == 3);
        if (statusB) wr(4'd10, 32'h2);
      end
    pulse();
    wr(4'd9, 32'd3);
    for (int k = 1; k <= 3; k++) begin
      pulse();
      chk("R8 reload on write", statusB, k == 3);
      if (statusB) wr(4'd10, 32'h2);
    end
    wr(4'd9, 32'd0);
    for (int k = 0; k < 2; k++) begin
      pulse();
      chk("R8 count zero", statusB, 1'b1);
      wr(4'd10, 32'h2);
    end

    // R9 set wins over clear, clear is per channel
    wr(4'd8, 32'h0);
    wr(4'd2, IE | ALLQ);
    plainBus(32'h1234_00A5);
    pulse();
    chk("R9 A set", statusA, 1'b1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd10; regWrData = 32'h3; busValid = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; busValid = 1'b0;
    chk("R9 set wins", statusA, 1'b1);
    plainBus(32'h200);
    pulse();
    chk("R9 B set", statusB, 1'b1);
    wr(4'd10, 32'h2);
    chk("R9 B cleared", statusB, 1'b0);
    chk("R9 A untouched", statusA, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule